// File: doc/BRIEF.md
# Table-Driven Packet Header Parser

The parser takes one packet byte per cycle and walks its headers by following a graph held in a small writable table. It does not assume any fixed protocol order. Each table entry describes one header type: its length, where its next-header selector sits, up to four selector-to-entry transitions, a default transition, and an extraction map. The extraction map copies chosen header bytes into a wide header vector, which is passed to the match stages. The walk always begins at entry 0. With a typical configuration, entry 0 is an Ethernet-like header with a 16-bit type selector. From there the graph can fan out to tag, IPv4-like or IPv6-like headers, and from an IP header to TCP, UDP or a custom header. A new header type can be placed between two existing ones by rewriting table entries only.

The graph is loaded through a configuration write port that replaces one whole entry per write. Writes are accepted only between packets, so a packet is always parsed against a single, consistent graph. Each packet produces exactly one result pulse. The vector-valid pulse means a transition marked "done" was reached. The error pulse means the selector matched nothing, or the packet ended too early.

Top module: `hdr_parser`

## Requirements
- R1: While reset is held, and after it is released, hv_valid_o and err_o are low and hv_o is all zero. Reset clears every graph entry, so a packet sent before any configuration ends in an error pulse.
- R2: cfg_data_i carries one entry, LSB first:
  - length in bytes [5:0]
  - selector offset [11:6]
  - selector width [12] (1 = 16-bit, 0 = 8-bit)
  - default enable [13], default done [14], default target [17:15]
  - transition slot t at bits [18+21t +: 21], laid out as value [15:0], enable [16], done [17], target [20:18]
  - extraction slot s at bits [102+14s +: 14], laid out as enable [0], header byte offset [6:1], vector byte position [13:7]

  A write replaces entry cfg_node_i only if, in that cycle, the parser is between packets and no packet start is presented. Any other write is discarded.
- R3: A packet begins with a valid byte that carries in_sop_i while the parser is idle, and parsing starts at entry 0. Valid bytes presented while idle without in_sop_i are ignored.
- R4: A header covers the entry's length in bytes, where a length of 0 counts as 1. In 8-bit mode the selector is the byte at the selector offset. In 16-bit mode it is the bytes at the offset and the offset plus 1, taken big-endian.
- R5: An enabled transition slot matches when its value equals the selector; in 8-bit mode only value [7:0] is compared. If several slots match, the lowest-numbered one is used. A match with done set ends the walk; otherwise the next header is parsed with the target entry.
- R6: If no slot matches, the default is used when it is enabled. If the default is not enabled, the packet ends in an error.
- R7: The packet ends in an error if in_eop_i arrives before the last byte of the current header. It also ends in an error if in_eop_i arrives on a last byte whose decision names a further header.
- R8: In every header byte, each enabled extraction slot whose offset equals the byte's index copies that byte into vector byte k, which is hv_o[8k+7:8k]. A position at or beyond HV_BYTES is ignored. The vector is cleared to zero at each packet start.
- R9: Each packet yields exactly one one-cycle pulse, either hv_valid_o or err_o, never both. The pulse appears in the cycle after the byte that settled the outcome.
- R10: Once the walk has ended, the remaining bytes up to in_eop_i are ignored. A new packet may start in the cycle right after in_eop_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Byte present this cycle |
| in_sop_i | input | 1 | First byte of a packet |
| in_eop_i | input | 1 | Last byte of a packet |
| in_data_i | input | 8 | Packet byte |
| cfg_we_i | input | 1 | Graph entry write strobe |
| cfg_node_i | input | 3 | Entry index to write |
| cfg_data_i | input | 158 | Entry contents, layout in R2 |
| hv_o | output | 8*HV_BYTES | Header vector |
| hv_valid_o | output | 1 | Walk reached a done transition |
| err_o | output | 1 | Walk failed |

## Verification
The hardest case to reach is a configuration write that arrives mid-packet or in the same cycle as a packet start. From the ports it looks like any other write, and it only shows up if the graph later misbehaves. The bench issues such writes so that they would blank entry 0, then sends a full packet and expects an intact vector. A write made while idle must break the next packet. A table of packets then steers the walk through a repeated tag header, an inserted custom header, a shadowed duplicate transition, and early ends at and inside header boundaries.

// File: rtl/hdr_parser_pkg.sv
package hdr_parser_pkg;
  localparam int NODE_W = 3;
  localparam int LEN_W  = 6;
  localparam int POS_W  = 7;
  localparam int SEL_W  = 16;
  localparam int N_TR   = 4;
  localparam int N_EXT  = 4;

  typedef struct packed {
    logic [POS_W-1:0] pos;
    logic [LEN_W-1:0] off;
    logic             en;
  } ext_t;

  typedef struct packed {
    logic [NODE_W-1:0] node;
    logic              done;
    logic              en;
    logic [SEL_W-1:0]  val;
  } tr_t;

  typedef struct packed {
    ext_t [N_EXT-1:0]  ext;
    tr_t  [N_TR-1:0]   tr;
    logic [NODE_W-1:0] def_node;
    logic              def_done;
    logic              def_en;
    logic              sel_two;
    logic [LEN_W-1:0]  sel_off;
    logic [LEN_W-1:0]  len;
  } node_t;

  localparam int NODE_BITS = $bits(node_t);

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_DRAIN} st_e;
endpackage

// File: rtl/pgp_graph_mem.sv
module pgp_graph_mem
  import hdr_parser_pkg::*;
#(
  parameter int N_NODES = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [NODE_W-1:0]          waddr_i,
  input  node_t                      wdata_i,
  input  logic [NODE_W-1:0]          raddr_i,
  output node_t                      rdata_o,
  output logic [N_NODES*NODE_BITS-1:0] flat_o
);
  node_t mem_q [N_NODES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_NODES; i++) mem_q[i] <= '0;
    end else if (we_i && (int'(waddr_i) < N_NODES)) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // out-of-range target reads as an empty entry, which fails the walk
  assign rdata_o = (int'(raddr_i) < N_NODES) ? mem_q[raddr_i] : '0;

  for (genvar g = 0; g < N_NODES; g++) begin : g_flat
    assign flat_o[g*NODE_BITS +: NODE_BITS] = mem_q[g];
  end
endmodule

// File: rtl/pgp_next_sel.sv
module pgp_next_sel
  import hdr_parser_pkg::*;
(
  input  tr_t [N_TR-1:0]     tr_i,
  input  logic               two_i,
  input  logic               def_en_i,
  input  logic               def_done_i,
  input  logic [NODE_W-1:0]  def_node_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               done_o,
  output logic               err_o,
  output logic [NODE_W-1:0]  next_o
);
  logic [N_TR-1:0] hit;

  for (genvar g = 0; g < N_TR; g++) begin : g_hit
    assign hit[g] = tr_i[g].en &&
                    (two_i ? (tr_i[g].val == sel_i) : (tr_i[g].val[7:0] == sel_i[7:0]));
  end

  always_comb begin
    done_o = def_done_i;
    next_o = def_node_i;
    err_o  = !def_en_i;
    // walk down so the lowest index wins
    for (int i = N_TR-1; i >= 0; i--) begin
      if (hit[i]) begin
        done_o = tr_i[i].done;
        next_o = tr_i[i].node;
        err_o  = 1'b0;
      end
    end
  end
endmodule

// File: rtl/pgp_extract.sv
module pgp_extract
  import hdr_parser_pkg::*;
#(
  parameter int HV_BYTES = 80
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   wr_i,
  input  logic [LEN_W-1:0]       idx_i,
  input  logic [7:0]             byte_i,
  input  ext_t [N_EXT-1:0]       ext_i,
  output logic [HV_BYTES*8-1:0]  hv_o
);
  logic [HV_BYTES*8-1:0] hv_q, hv_d;

  always_comb begin
    hv_d = clr_i ? '0 : hv_q;
    if (wr_i) begin
      for (int j = 0; j < N_EXT; j++) begin
        if (ext_i[j].en && ext_i[j].off == idx_i && int'(ext_i[j].pos) < HV_BYTES) begin
          hv_d[int'(ext_i[j].pos)*8 +: 8] = byte_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hv_q <= '0;
    else         hv_q <= hv_d;
  end

  assign hv_o = hv_q;
endmodule

// File: rtl/hdr_parser.sv
module hdr_parser
  import hdr_parser_pkg::*;
#(
  parameter int N_NODES  = 8,
  parameter int HV_BYTES = 80,
  localparam int HV_W    = HV_BYTES * 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  in_valid_i,
  input  logic                  in_sop_i,
  input  logic                  in_eop_i,
  input  logic [7:0]            in_data_i,
  input  logic                  cfg_we_i,
  input  logic [NODE_W-1:0]     cfg_node_i,
  input  logic [NODE_BITS-1:0]  cfg_data_i,
  output logic [HV_W-1:0]       hv_o,
  output logic                  hv_valid_o,
  output logic                  err_o
);
  st_e                st_q;
  logic [NODE_W-1:0]  node_q;
  logic [LEN_W-1:0]   idx_q;
  logic [SEL_W-1:0]   sel_q;
  logic               hv_valid_q, err_q;

  logic               start, proc, last, cfg_ok, busy, in_drain;
  logic [NODE_W-1:0]  cur_node, dec_next;
  logic [LEN_W-1:0]   cur_idx;
  logic [SEL_W-1:0]   cur_sel, sel_nxt;
  logic               dec_done, dec_err;
  node_t              ent;
  logic [N_NODES*NODE_BITS-1:0] graph_flat;

  assign start    = in_valid_i && in_sop_i && (st_q == ST_IDLE);
  assign proc     = start || (in_valid_i && st_q == ST_HDR);
  assign cur_node = start ? '0 : node_q;
  assign cur_idx  = start ? '0 : idx_q;
  assign cur_sel  = start ? '0 : sel_q;
  assign cfg_ok   = cfg_we_i && (st_q == ST_IDLE) && !start;
  assign busy     = (st_q != ST_IDLE);
  assign in_drain = (st_q == ST_DRAIN);

  pgp_graph_mem #(.N_NODES(N_NODES)) graph_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_ok),
    .waddr_i (cfg_node_i),
    .wdata_i (node_t'(cfg_data_i)),
    .raddr_i (cur_node),
    .rdata_o (ent),
    .flat_o  (graph_flat)
  );

  assign last = ({1'b0, cur_idx} + 7'd1) >= {1'b0, ent.len};

  // selector as it stands once the current byte is included
  always_comb begin
    sel_nxt = cur_sel;
    if (cur_idx == ent.sel_off) begin
      if (ent.sel_two) sel_nxt[15:8] = in_data_i;
      else             sel_nxt = {8'h00, in_data_i};
    end
    if (ent.sel_two && cur_idx == ent.sel_off + 6'd1) sel_nxt[7:0] = in_data_i;
  end

  pgp_next_sel next_i (
    .tr_i       (ent.tr),
    .two_i      (ent.sel_two),
    .def_en_i   (ent.def_en),
    .def_done_i (ent.def_done),
    .def_node_i (ent.def_node),
    .sel_i      (sel_nxt),
    .done_o     (dec_done),
    .err_o      (dec_err),
    .next_o     (dec_next)
  );

  pgp_extract #(.HV_BYTES(HV_BYTES)) ext_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start),
    .wr_i   (proc),
    .idx_i  (cur_idx),
    .byte_i (in_data_i),
    .ext_i  (ent.ext),
    .hv_o   (hv_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      node_q     <= '0;
      idx_q      <= '0;
      sel_q      <= '0;
      hv_valid_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      hv_valid_q <= 1'b0;
      err_q      <= 1'b0;
      if (proc) begin
        if (last) begin
          if (dec_err) begin
            err_q <= 1'b1;
            st_q  <= in_eop_i ? ST_IDLE : ST_DRAIN;
          end else if (dec_done) begin
            hv_valid_q <= 1'b1;
            st_q       <= in_eop_i ? ST_IDLE : ST_DRAIN;
          end else if (in_eop_i) begin
            err_q <= 1'b1;
            st_q  <= ST_IDLE;
          end else begin
            node_q <= dec_next;
            idx_q  <= '0;
            sel_q  <= '0;
            st_q   <= ST_HDR;
          end
        end else if (in_eop_i) begin
          err_q <= 1'b1;
          st_q  <= ST_IDLE;
        end else begin
          node_q <= cur_node;
          idx_q  <= cur_idx + 6'd1;
          sel_q  <= sel_nxt;
          st_q   <= ST_HDR;
        end
      end else if (in_drain && in_valid_i && in_eop_i) begin
        st_q <= ST_IDLE;
      end
    end
  end

  assign hv_valid_o = hv_valid_q;
  assign err_o      = err_q;
endmodule

// File: rtl/hdr_parser_chk.sv
module pgp_chk
  import hdr_parser_pkg::*;
#(
  parameter int N_NODES = 8
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         in_valid_i,
  input logic                         cfg_we_i,
  input logic                         hv_valid_o,
  input logic                         err_o,
  input logic                         busy_i,
  input logic                         drain_i,
  input logic [N_NODES*NODE_BITS-1:0] graph_i
);
  // R9
  excl_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hv_valid_o && err_o));

  // R9
  pulse_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hv_valid_o || err_o) |-> $past(in_valid_i));

  // R2
  cfg_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && busy_i) |=> $stable(graph_i));

  // R10
  drain_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain_i && $past(drain_i)) |-> (!hv_valid_o && !err_o));
endmodule

bind hdr_parser pgp_chk #(.N_NODES(N_NODES)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .cfg_we_i   (cfg_we_i),
  .hv_valid_o (hv_valid_o),
  .err_o      (err_o),
  .busy_i     (busy),
  .drain_i    (in_drain),
  .graph_i    (graph_flat)
);

// File: tb/hdr_parser_tb.sv
`timescale 1ns/1ps
module hdr_parser_tb_top;
  localparam int NB   = 158;
  localparam int HV_W = 640;

  typedef struct packed {
    logic [4:0]   len;
    logic         err;
    logic [79:0]  hv;
    logic [127:0] b;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    // R5 R8 plain IP/TCP, shadowed duplicate transition
    '{5'd9,  1'b0, 80'h0800_0000_0044_3311_BBAA,
      128'h00_00_00_00_00_00_00_44_33_06_22_11_00_08_BB_AA},
    // R4 R8 repeated tag header, UDP, out-of-range slot
    '{5'd14, 1'b0, 80'h8100_0700_7700_0055_BBAA,
      128'h00_00_77_11_66_55_00_08_07_00_81_05_00_81_BB_AA},
    // R6 IPv6-like node with no way out
    '{5'd6,  1'b1, 80'h0,
      128'h00_00_00_00_00_00_00_00_00_00_02_01_DD_86_BB_AA},
    // R5 custom header inserted between IP and TCP
    '{5'd11, 1'b0, 80'h0800_0006_0044_3311_BBAA,
      128'h00_00_00_00_00_44_33_06_C1_FD_22_11_00_08_BB_AA},
    // R6 unknown type, trailing bytes drained
    '{5'd6,  1'b1, 80'h0,
      128'h00_00_00_00_00_00_00_00_00_00_00_00_34_12_BB_AA},
    // R7 end inside a header
    '{5'd5,  1'b1, 80'h0,
      128'h00_00_00_00_00_00_00_00_00_00_00_11_00_08_BB_AA},
    // R7 end on header boundary with more to come
    '{5'd4,  1'b1, 80'h0,
      128'h00_00_00_00_00_00_00_00_00_00_00_00_00_08_BB_AA},
    // R10 payload after done ignored
    '{5'd11, 1'b0, 80'h0800_0000_0044_3311_BBAA,
      128'h00_00_00_00_00_AD_DE_44_33_06_22_11_00_08_BB_AA}
  };

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            in_valid_i = 1'b0, in_sop_i = 1'b0, in_eop_i = 1'b0;
  logic [7:0]      in_data_i = '0;
  logic            cfg_we_i = 1'b0;
  logic [2:0]      cfg_node_i = '0;
  logic [NB-1:0]   cfg_data_i = '0;
  logic [HV_W-1:0] hv_o;
  logic            hv_valid_o, err_o;

  int n_chk = 0, n_fail = 0, n_ok = 0, n_err = 0;
  logic [HV_W-1:0] cap_hv = '0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  hdr_parser dut_i (.*);

  always @(negedge clk_i) begin
    if (hv_valid_o) begin n_ok++; cap_hv = hv_o; end
    if (err_o) n_err++;
  end

  function automatic logic [20:0] tr(input logic [15:0] v, input logic dn, input logic [2:0] nd);
    return {nd, dn, 1'b1, v};
  endfunction
  function automatic logic [13:0] ex(input logic [5:0] off, input logic [6:0] pos);
    return {pos, off, 1'b1};
  endfunction
  function automatic logic [NB-1:0] mk(input logic [5:0] len, input logic [5:0] off,
      input logic two, input logic den, input logic ddn, input logic [2:0] dnd,
      input logic [83:0] trs, input logic [55:0] exs);
    return {exs, trs, dnd, ddn, den, two, off, len};
  endfunction

  logic [NB-1:0] n0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_node(input logic [2:0] n, input logic [NB-1:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_node_i = n; cfg_data_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic send(input logic [127:0] b, input int n, input int wr_at);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      in_valid_i = 1'b1; in_sop_i = (i == 0); in_eop_i = (i == n-1);
      in_data_i  = b[i*8 +: 8];
      cfg_we_i   = (i == wr_at); cfg_node_i = '0; cfg_data_i = '0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      in_valid_i = 1'b0; in_sop_i = 1'b0; in_eop_i = 1'b0; cfg_we_i = 1'b0;
    end
  endtask

  task automatic run_pkt(input int k, input int wr_at);
    n_ok = 0; n_err = 0;
    send(VEC[k].b, int'(VEC[k].len), wr_at);
    idle(4);
  endtask

  task automatic chk_ok(input string tag, input int k);
    chk({tag, " ok count"},  n_ok,  1);
    chk({tag, " err count"}, n_err, 0);
    chk({tag, " vector"}, {48'h0, cap_hv[79:0]}, {48'h0, VEC[k].hv});
  endtask

  initial begin
    n0 = mk(6'd4, 6'd2, 1'b1, 1'b0, 1'b0, 3'd0,
            {21'h0, tr(16'h86DD, 1'b0, 3'd3), tr(16'h8100, 1'b0, 3'd2), tr(16'h0800, 1'b0, 3'd1)},
            {ex(6'd3, 7'd8), ex(6'd2, 7'd9), ex(6'd1, 7'd1), ex(6'd0, 7'd0)});
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 hv_valid in reset", hv_valid_o, 0);
    chk("R1 err in reset", err_o, 0);
    chk("R1 vector in reset", |hv_o, 0);
    rst_ni = 1'b1;
    idle(2);
    chk("R1 vector after reset", |hv_o, 0);
    n_ok = 0; n_err = 0;
    send(128'hAA, 1, -1);
    idle(3);
    chk("R1 empty graph errors", {n_ok, n_err}, {32'd0, 32'd1});

    wr_node(3'd0, n0);
    wr_node(3'd1, mk(6'd3, 6'd2, 1'b0, 1'b0, 1'b0, 3'd0,
      {tr(16'h0006, 1'b0, 3'd5), tr(16'h00FD, 1'b0, 3'd6), tr(16'h0011, 1'b0, 3'd5), tr(16'h0006, 1'b0, 3'd4)},
      {42'h0, ex(6'd0, 7'd2)}));
    wr_node(3'd2, mk(6'd3, 6'd1, 1'b1, 1'b0, 1'b0, 3'd0,
      {42'h0, tr(16'h0800, 1'b0, 3'd1), tr(16'h8100, 1'b0, 3'd2)}, {42'h0, ex(6'd0, 7'd7)}));
    wr_node(3'd3, mk(6'd2, 6'd0, 1'b1, 1'b0, 1'b0, 3'd0, 84'h0, 56'h0));
    wr_node(3'd4, mk(6'd2, 6'd0, 1'b0, 1'b1, 1'b1, 3'd0, 84'h0, {28'h0, ex(6'd1, 7'd4), ex(6'd0, 7'd3)}));
    wr_node(3'd5, mk(6'd1, 6'd0, 1'b0, 1'b1, 1'b1, 3'd0, 84'h0, {28'h0, ex(6'd0, 7'd90), ex(6'd0, 7'd5)}));
    wr_node(3'd6, mk(6'd2, 6'd1, 1'b0, 1'b0, 1'b0, 3'd0, {63'h0, tr(16'h0006, 1'b0, 3'd4)}, {42'h0, ex(6'd1, 7'd6)}));

    // R4 R5 R6 R7 R8 R10 table walk
    for (int k = 0; k < NV; k++) begin
      run_pkt(k, -1);
      if (VEC[k].err) begin
        chk($sformatf("R6 R7 row %0d ok count", k), n_ok, 0);
        chk($sformatf("R6 R7 row %0d err count", k), n_err, 1);
      end else begin
        chk_ok($sformatf("R8 row %0d", k), k);
        chk($sformatf("R8 row %0d upper vector", k), |cap_hv[HV_W-1:80], 0);
      end
    end

    // R9 pulse timing: cycle after the deciding byte, one cycle wide
    n_ok = 0; n_err = 0;
    send(VEC[0].b, 9, -1);
    @(negedge clk_i);
    in_valid_i = 1'b0; in_sop_i = 1'b0; in_eop_i = 1'b0;
    chk("R9 pulse after last byte", {hv_valid_o, err_o}, 2'b10);
    @(negedge clk_i);
    chk("R9 pulse one cycle", {hv_valid_o, err_o}, 2'b00);
    idle(2);

    // R3 stray bytes while idle
    n_ok = 0; n_err = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      in_valid_i = 1'b1; in_sop_i = 1'b0; in_eop_i = (i == 4); in_data_i = 8'hAA;
    end
    idle(4);
    chk("R3 stray bytes no pulse", {n_ok, n_err}, 64'd0);
    run_pkt(0, -1);
    chk_ok("R3 packet after stray bytes", 0);

    // R10 back-to-back packets
    n_ok = 0; n_err = 0;
    send(VEC[0].b, 9, -1);
    send(VEC[1].b, 14, -1);
    idle(4);
    chk("R10 back-to-back ok count", n_ok, 2);
    chk("R10 back-to-back vector", {48'h0, cap_hv[79:0]}, {48'h0, VEC[1].hv});

    // R2 writes mid-packet and on the start cycle are dropped
    run_pkt(0, 2);
    chk_ok("R2 write mid-packet", 0);
    run_pkt(0, 0);
    chk_ok("R2 write on sop", 0);
    run_pkt(0, -1);
    chk_ok("R2 graph intact", 0);
    // R2 idle write takes effect
    wr_node(3'd0, '0);
    run_pkt(0, -1);
    chk("R2 idle write applied", {n_ok, n_err}, {32'd0, 32'd1});
    wr_node(3'd0, n0);
    run_pkt(3, -1);
    chk_ok("R2 restored entry", 3);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R9 act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule